// File: doc/BRIEF.md
# Processor Status Interrupt Aggregator

This block watches four status lines from each of ten processors: a reset indicator, a boot-in-progress indicator, a host-event line and a watchdog line. Every line is brought into the local clock domain through a synchroniser chain. The synchronised levels can be read over a Wishbone slave port with 32-bit data.

Selected transitions on these lines set sticky per-lane pending flags. Each group of pending flags has its own mask register. The masked pending flags are combined into two registered, active-low interrupt lines for a host controller. One line reports host-side activity (boot and host-event transitions). The other reports failures (a watchdog firing, or a processor dropping into reset while it is not booting). Software clears a pending flag by writing a one to its bit.

Register addresses are byte addresses. Bits [5:4] select the bank: 0 for status, 1 for pending, 2 for mask. Bits [3:2] select the group: 0 for reset, 1 for boot, 2 for host event, 3 for watchdog. Lane i is always bit i.

Top module: `proc_status_irq`

## Requirements
- R1: After reset, every pending and mask register reads 0 and both interrupt outputs are high, whatever the status input levels are.
- R2: The status registers 0x00 (reset), 0x04 (boot), 0x08 (host event) and 0x0C (watchdog) return the input level of lane i in bit i, two clock edges after the input changes. Writes to them have no effect.
- R3: Any transition, in either direction, on a boot or host-event input of lane i sets bit i of 0x14 (boot) or 0x18 (host event).
- R4: A low-to-high transition on the watchdog input of lane i sets bit i of 0x1C. A high-to-low transition sets nothing.
- R5: A high-to-low transition on the reset input of lane i sets bit i of 0x10 only while the boot input of that lane is high (not booting). A falling edge during boot sets nothing, and neither does a rising edge.
- R6: Pending bits stay set until a one is written to them at 0x10 to 0x1C. Writing a zero leaves a bit unchanged. If an event and a clear arrive in the same cycle, the event wins.
- R7: The host output goes low when a pending bit in 0x14 or 0x18 has its mask bit set at 0x24 or 0x28. The failure output goes low when a pending bit in 0x10 or 0x1C has its mask bit set at 0x20 or 0x2C. Each output returns high once no such pair remains.
- R8: The mask registers read back the written bits [9:0], and their upper bits read 0. Addresses outside 0x00 to 0x2C read 0, and writes to them have no effect.
- R9: Every Wishbone access is answered with a one-cycle acknowledge on the clock edge after the strobe is sampled, and read data is valid together with that acknowledge.
- R10: With the matching mask bit set, an interrupt output goes low on the fourth clock edge after an input transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 8 | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| cpu_rst_n_i | input | 10 | Per-lane reset status, low means held in reset |
| cpu_boot_n_i | input | 10 | Per-lane boot status, low means booting |
| cpu_hev_i | input | 10 | Per-lane host-event line |
| cpu_wdog_i | input | 10 | Per-lane watchdog line, high means fired |
| irq_host_n_o | output | 1 | Host-activity interrupt, active low |
| irq_fail_n_o | output | 1 | Failure interrupt, active low |

## Verification
The block's results arrive on different schedules:
- A status level is readable two edges after its input changes.
- A pending flag is set on the third edge.
- An interrupt output moves on the fourth edge.
- A Wishbone acknowledge, with its data, comes one edge after the strobe.
- A cleared flag shows up on its interrupt line one edge after the write.

The bench drives every input at a falling edge and samples at later falling edges. Latency checks sample exactly on both sides of the due edge. Register checks wait six edges, which is past every pipeline stage. For each access, the bench counts the falling edges until the acknowledge appears and checks that the count is one.

// File: rtl/psi_pkg.sv
package psi_pkg;
   localparam int unsigned GRP_CNT = 4;
   localparam int unsigned GRP_RST  = 0;
   localparam int unsigned GRP_BOOT = 1;
   localparam int unsigned GRP_HEV  = 2;
   localparam int unsigned GRP_WDOG = 3;
   // Quiet level of each group's input, one bit per group
   localparam logic [GRP_CNT-1:0] GRP_IDLE = 4'b0011;
   localparam logic [1:0] BANK_STAT = 2'd0;
   localparam logic [1:0] BANK_PEND = 2'd1;
   localparam logic [1:0] BANK_MASK = 2'd2;
endpackage

// File: rtl/psi_sync.sv
module psi_sync #(
   parameter int unsigned WIDTH   = 10,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("psi_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/psi_detect.sv
module psi_detect
   import psi_pkg::*;
#(
   parameter int unsigned N_LANE        = 10,
   parameter int unsigned ARM_CYC       = 3,
   parameter bit          WDOG_ANY_EDGE = 1'b0
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic [GRP_CNT-1:0][N_LANE-1:0]  sync_i,
   output logic [GRP_CNT-1:0][N_LANE-1:0]  evt_o
);
   localparam int unsigned CNT_W = $clog2(ARM_CYC + 1);

   logic [GRP_CNT-1:0][N_LANE-1:0] prev_q;
   logic [CNT_W-1:0]               arm_cnt_q;
   logic                           armed;
   logic [GRP_CNT-1:0][N_LANE-1:0] raw_evt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         arm_cnt_q <= '0;
         for (int g = 0; g < GRP_CNT; g++) prev_q[g] <= {N_LANE{GRP_IDLE[g]}};
      end else begin
         prev_q <= sync_i;
         if (!armed) arm_cnt_q <= arm_cnt_q + 1'b1;
      end
   end

   assign armed = (arm_cnt_q == CNT_W'(ARM_CYC));

   // Reset entry counts only when the lane is not booting
   assign raw_evt[GRP_RST]  = prev_q[GRP_RST] & ~sync_i[GRP_RST] & sync_i[GRP_BOOT];
   assign raw_evt[GRP_BOOT] = prev_q[GRP_BOOT] ^ sync_i[GRP_BOOT];
   assign raw_evt[GRP_HEV]  = prev_q[GRP_HEV] ^ sync_i[GRP_HEV];

   if (WDOG_ANY_EDGE) begin : g_wdog_both
      assign raw_evt[GRP_WDOG] = prev_q[GRP_WDOG] ^ sync_i[GRP_WDOG];
   end else begin : g_wdog_rise
      assign raw_evt[GRP_WDOG] = ~prev_q[GRP_WDOG] & sync_i[GRP_WDOG];
   end

   assign evt_o = armed ? raw_evt : '0;
endmodule

// File: rtl/psi_regs.sv
module psi_regs
   import psi_pkg::*;
#(
   parameter int unsigned N_LANE = 10,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            cyc_i,
   input  logic                            stb_i,
   input  logic                            we_i,
   input  logic [ADDR_W-1:0]               adr_i,
   input  logic [DATA_W-1:0]               dat_i,
   output logic [DATA_W-1:0]               dat_o,
   output logic                            ack_o,
   input  logic [GRP_CNT-1:0][N_LANE-1:0]  stat_i,
   input  logic [GRP_CNT-1:0][N_LANE-1:0]  evt_i,
   output logic [GRP_CNT-1:0][N_LANE-1:0]  pend_o,
   output logic [GRP_CNT-1:0][N_LANE-1:0]  mask_o
);
   logic                           access, wr, in_range;
   logic [1:0]                     bank;
   logic [1:0]                     grp;
   logic [GRP_CNT-1:0][N_LANE-1:0] clr, hold;
   logic [N_LANE-1:0]              sel_vec;
   logic [DATA_W-1:0]              rd_val;
   logic [DATA_W-1:0]              rdat_q;
   logic                           ack_q;
   logic [GRP_CNT-1:0][N_LANE-1:0] pend_q, mask_q;
   logic                           unused_bits;

   assign unused_bits = ^{dat_i[DATA_W-1:N_LANE], adr_i[1:0]};

   assign access   = cyc_i & stb_i & ~ack_q;
   assign wr       = access & we_i;
   assign in_range = (adr_i[ADDR_W-1:6] == '0) && (adr_i[5:4] != 2'd3);
   assign bank     = adr_i[5:4];
   assign grp      = adr_i[3:2];

   for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
      assign clr[g]  = (wr && in_range && bank == BANK_PEND && grp == 2'(g))
                       ? dat_i[N_LANE-1:0] : '0;
      assign hold[g] = pend_q[g] & ~clr[g];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pend_q[g] <= '0;
            mask_q[g] <= '0;
         end else begin
            pend_q[g] <= hold[g] | evt_i[g];
            if (wr && in_range && bank == BANK_MASK && grp == 2'(g))
               mask_q[g] <= dat_i[N_LANE-1:0];
         end
      end

      p_pend_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (|evt_i[g]) |=> ((pend_q[g] & $past(evt_i[g])) == $past(evt_i[g])));
      p_pend_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ((pend_q[g] & $past(hold[g])) == $past(hold[g])));
   end

   always_comb begin
      case (bank)
         BANK_STAT: sel_vec = stat_i[grp];
         BANK_PEND: sel_vec = pend_q[grp];
         default:   sel_vec = mask_q[grp];
      endcase
      rd_val = '0;
      if (in_range) rd_val[N_LANE-1:0] = sel_vec;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ack_q  <= 1'b0;
         rdat_q <= '0;
      end else begin
         ack_q <= access;
         if (access && !we_i) rdat_q <= rd_val;
      end
   end

   assign dat_o  = rdat_q;
   assign ack_o  = ack_q;
   assign pend_o = pend_q;
   assign mask_o = mask_q;

   p_ack_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_q |=> !ack_q);
   p_ack_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_i && stb_i && !ack_q) |=> ack_q);
endmodule

// File: rtl/proc_status_irq.sv
module proc_status_irq
   import psi_pkg::*;
#(
   parameter int unsigned N_LANE        = 10,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          WDOG_ANY_EDGE = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wb_cyc_i,
   input  logic              wb_stb_i,
   input  logic              wb_we_i,
   input  logic [ADDR_W-1:0] wb_adr_i,
   input  logic [DATA_W-1:0] wb_dat_i,
   output logic [DATA_W-1:0] wb_dat_o,
   output logic              wb_ack_o,
   input  logic [N_LANE-1:0] cpu_rst_n_i,
   input  logic [N_LANE-1:0] cpu_boot_n_i,
   input  logic [N_LANE-1:0] cpu_hev_i,
   input  logic [N_LANE-1:0] cpu_wdog_i,
   output logic              irq_host_n_o,
   output logic              irq_fail_n_o
);
   localparam int unsigned ARM_CYC = SYNC_STAGES + 1;

   if (N_LANE >= DATA_W || N_LANE == 0) begin : g_bad_lanes
      $error("proc_status_irq: N_LANE must be 1..DATA_W-1");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("proc_status_irq: ADDR_W must be at least 7");
   end

   logic [GRP_CNT-1:0][N_LANE-1:0] raw, sync, evt, pend, mask;
   logic host_req, fail_req;
   logic irq_host_q, irq_fail_q;

   assign raw[GRP_RST]  = cpu_rst_n_i;
   assign raw[GRP_BOOT] = cpu_boot_n_i;
   assign raw[GRP_HEV]  = cpu_hev_i;
   assign raw[GRP_WDOG] = cpu_wdog_i;

   for (genvar g = 0; g < GRP_CNT; g++) begin : g_sync
      psi_sync #(
         .WIDTH  (N_LANE),
         .STAGES (SYNC_STAGES),
         .RST_VAL({N_LANE{GRP_IDLE[g]}})
      ) u_sync (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .d_i   (raw[g]),
         .q_o   (sync[g])
      );
   end

   psi_detect #(
      .N_LANE       (N_LANE),
      .ARM_CYC      (ARM_CYC),
      .WDOG_ANY_EDGE(WDOG_ANY_EDGE)
   ) u_detect (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sync_i(sync),
      .evt_o (evt)
   );

   psi_regs #(
      .N_LANE(N_LANE),
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W)
   ) u_regs (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cyc_i (wb_cyc_i),
      .stb_i (wb_stb_i),
      .we_i  (wb_we_i),
      .adr_i (wb_adr_i),
      .dat_i (wb_dat_i),
      .dat_o (wb_dat_o),
      .ack_o (wb_ack_o),
      .stat_i(sync),
      .evt_i (evt),
      .pend_o(pend),
      .mask_o(mask)
   );

   assign host_req = |((pend[GRP_BOOT] & mask[GRP_BOOT]) | (pend[GRP_HEV] & mask[GRP_HEV]));
   assign fail_req = |((pend[GRP_RST] & mask[GRP_RST]) | (pend[GRP_WDOG] & mask[GRP_WDOG]));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_host_q <= 1'b1;
         irq_fail_q <= 1'b1;
      end else begin
         irq_host_q <= ~host_req;
         irq_fail_q <= ~fail_req;
      end
   end

   assign irq_host_n_o = irq_host_q;
   assign irq_fail_n_o = irq_fail_q;

   p_host_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_host_n_o |-> $past(|(mask[GRP_BOOT] | mask[GRP_HEV])));
   p_fail_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_fail_n_o |-> $past(|(mask[GRP_RST] | mask[GRP_WDOG])));
endmodule

// File: tb/sim_proc_status_irq.sv
module sim_proc_status_irq;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_LIMIT = 20000;

   typedef struct packed {
      logic        we;
      logic [7:0]  adr;
      logic [31:0] dat;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 13;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 8'h20, 32'h0,        32'h0,   4'd1},  // R1 mask reset
      '{1'b0, 8'h10, 32'h0,        32'h0,   4'd1},  // R1 pending reset
      '{1'b0, 8'h00, 32'h0,        32'h3FF, 4'd2},  // R2 reset status idle high
      '{1'b0, 8'h04, 32'h0,        32'h3FF, 4'd2},  // R2 boot status
      '{1'b0, 8'h08, 32'h0,        32'h0,   4'd2},  // R2 host event status
      '{1'b1, 8'h24, 32'hFFFFFFFF, 32'h0,   4'd8},  // R8 write mask
      '{1'b0, 8'h24, 32'h0,        32'h3FF, 4'd8},  // R8 upper bits zero
      '{1'b1, 8'h00, 32'h0,        32'h0,   4'd2},  // R2 status write ignored
      '{1'b0, 8'h00, 32'h0,        32'h3FF, 4'd2},
      '{1'b1, 8'h30, 32'h123,      32'h0,   4'd8},  // R8 unmapped
      '{1'b0, 8'h30, 32'h0,        32'h0,   4'd8},
      '{1'b1, 8'h24, 32'h0,        32'h0,   4'd8},
      '{1'b0, 8'h24, 32'h0,        32'h0,   4'd8}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [7:0]  adr = '0;
   logic [31:0] wdat = '0;
   logic [31:0] rdat;
   logic        ack;
   logic [9:0]  c_rst = '1, c_boot = '1, c_hev = '0, c_wd = '0;
   logic        irq_host_n, irq_fail_n;

   int n_checks = 0;
   int n_errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   proc_status_irq u0 (
      .clk_i(clk), .rst_ni(rst_n),
      .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
      .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
      .cpu_rst_n_i(c_rst), .cpu_boot_n_i(c_boot), .cpu_hev_i(c_hev), .cpu_wdog_i(c_wd),
      .irq_host_n_o(irq_host_n), .irq_fail_n_o(irq_fail_n)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WDOG_LIMIT) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WDOG_LIMIT);
         finish_run();
      end
   end

   task automatic xfer(input logic w, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] q, output int waits);
      @(negedge clk);
      cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
      waits = 0;
      do begin
         @(negedge clk);
         waits++;
      end while (!ack && waits < 20);
      q = rdat;
      cyc = 1'b0; stb = 1'b0; we = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      logic [31:0] q;
      int w;
      xfer(1'b1, a, d, q, w);
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] q;
      int w;
      xfer(1'b0, a, 32'h0, q, w);
      check(tag, q, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] q;
      int w;
      idle(3);
      rst_n = 1'b1;
      idle(8);
      check("R1 host irq after reset", 32'(irq_host_n), 32'h1);
      check("R1 fail irq after reset", 32'(irq_fail_n), 32'h1);

      // Vector table walk
      for (int i = 0; i < NVEC; i++) begin
         xfer(VECS[i].we, VECS[i].adr, VECS[i].dat, q, w);
         if (!VECS[i].we)
            check($sformatf("R%0d vector %0d", VECS[i].req, i), q, VECS[i].exp);
      end

      // R9: single-edge acknowledge latency
      xfer(1'b0, 8'h04, 32'h0, q, w);
      check("R9 ack latency", 32'(w), 32'd1);
      @(posedge clk); #1;
      check("R9 ack one cycle", 32'(ack), 32'h0);

      // R10 / R3: host-event latency on lane 3
      wr(8'h28, 32'h008);
      @(negedge clk); c_hev[3] = 1'b1;
      idle(3);
      check("R10 host irq still high at edge 3", 32'(irq_host_n), 32'h1);
      idle(1);
      check("R10 host irq low at edge 4", 32'(irq_host_n), 32'h0);
      rd_chk("R3 host event rise pending", 8'h18, 32'h008);
      rd_chk("R2 host event status", 8'h08, 32'h008);
      wr(8'h18, 32'h008);
      rd_chk("R6 write one clears", 8'h18, 32'h0);
      idle(1);
      check("R7 host irq released", 32'(irq_host_n), 32'h1);
      @(negedge clk); c_hev[3] = 1'b0;
      idle(6);
      rd_chk("R3 host event fall pending", 8'h18, 32'h008);
      wr(8'h18, 32'h0);
      rd_chk("R6 write zero keeps", 8'h18, 32'h008);
      wr(8'h18, 32'h008);
      idle(2);

      // R4: watchdog lane 7
      @(negedge clk); c_wd[7] = 1'b1;
      idle(6);
      rd_chk("R4 watchdog rise pending", 8'h1C, 32'h080);
      check("R7 fail irq masked off", 32'(irq_fail_n), 32'h1);
      wr(8'h2C, 32'h080);
      idle(1);
      check("R7 fail irq unmasked", 32'(irq_fail_n), 32'h0);
      wr(8'h1C, 32'h080);
      idle(1);
      check("R7 fail irq after clear", 32'(irq_fail_n), 32'h1);
      @(negedge clk); c_wd[7] = 1'b0;
      idle(6);
      rd_chk("R4 watchdog fall ignored", 8'h1C, 32'h0);

      // R5: unexpected reset entry
      wr(8'h20, 32'h3FF);
      @(negedge clk); c_rst[2] = 1'b0;
      idle(6);
      rd_chk("R5 reset entry pending", 8'h10, 32'h004);
      check("R7 fail irq on reset entry", 32'(irq_fail_n), 32'h0);
      wr(8'h10, 32'h004);
      @(negedge clk); c_rst[2] = 1'b1;
      idle(6);
      rd_chk("R5 reset exit ignored", 8'h10, 32'h0);
      check("R7 fail irq idle", 32'(irq_fail_n), 32'h1);
      @(negedge clk); c_boot[5] = 1'b0;
      idle(6);
      rd_chk("R3 boot change pending", 8'h14, 32'h020);
      @(negedge clk); c_rst[5] = 1'b0;
      idle(6);
      rd_chk("R5 reset during boot ignored", 8'h10, 32'h0);
      check("R7 host irq boot masked off", 32'(irq_host_n), 32'h1);
      @(negedge clk); c_rst[5] = 1'b1; c_boot[5] = 1'b1;
      idle(6);

      // R1: reset in mid-run
      wr(8'h28, 32'h001);
      @(negedge clk); c_hev[0] = 1'b1;
      idle(6);
      check("R7 host irq lane 0", 32'(irq_host_n), 32'h0);
      rst_n = 1'b0;
      #1;
      check("R1 host irq in reset", 32'(irq_host_n), 32'h1);
      idle(2);
      rst_n = 1'b1;
      idle(8);
      rd_chk("R1 host pending after reset", 8'h18, 32'h0);
      rd_chk("R1 host mask after reset", 8'h28, 32'h0);
      rd_chk("R2 host status after reset", 8'h08, 32'h001);

      finish_run();
   end
endmodule